// File: doc/BRIEF.md
# Serial Configuration Loader with Daisy-Chain Forwarding

This block takes a bit-serial configuration stream on a single data pin and turns it into fixed-width words for the device's internal configuration memory. Each bit is taken on a rising edge of a configuration clock. A three-bit mode input picks where that clock comes from. In slave operation it arrives from outside and is brought into the system clock domain. In master operation the block makes the clock itself from a programmable divider on the system clock and drives it out.

In master operation the clock always starts at a slow default half-period. The first word of the stream carries a rate request. If that request is nonzero, it replaces the half-period from the next falling edge of the generated clock onward. The change waits for a period boundary, so no shortened pulse is ever produced.

A parameter sets how many bits belong to this device. When that many bits have been taken, a done flag rises and the loader stops writing words. From then on, every further incoming bit is forwarded to the serial output after the next falling clock edge, so a downstream device on the same chain can be loaded. Until the block's own load is complete, the serial output rests high.

Top module: `serial_cfg_loader`

## Requirements
- R1: Mode input 3'b111 selects slave operation and 3'b000 selects master operation. Every other code is off: the block takes no bits, emits no words, and holds cclk_o and cclk_oe_o low.
- R2: In slave operation, cclk_i and din_i each pass through a two-stage synchronizer. The din_i value is taken on each rising edge seen on cclk_i, which needs a high phase and a low phase of at least 3 system clocks each.
- R3: Bits are packed most significant first: the first bit taken in a word lands in bit WORD_W-1. Each completed word gives a one-cycle word_valid_o pulse, with word_addr_o counting up from 0. The pulse comes only in the cycle after a bit was taken.
- R4: In master operation, cclk_oe_o is high and cclk_o starts low after reset. Each half-period lasts DEF_HALF system clocks, and bits are taken on the clock edge where cclk_o rises.
- R5: In master operation, the value of word 0 is a rate request. A value of 0 keeps DEF_HALF. A nonzero value becomes the new half-period, raised to MIN_HALF if it is smaller. The new half-period applies from the first falling edge of cclk_o after word 0 completes. Only word 0 is used for this.
- R6: The half-period changes only on the clock edge where cclk_o falls, so the high and low phases of every generated period have equal length.
- R7: done_o rises in the same cycle as the pulse for the last word, once OWN_BITS bits have been taken. It stays high until reset, and no further words are emitted.
- R8: While done_o is low, dout_o is held at 1.
- R9: After done_o, each bit taken on a rising edge appears on dout_o after the next falling edge of the configuration clock. In master operation this happens on the same system clock edge where cclk_o falls.
- R10: During and right after reset, done_o and word_valid_o are 0, dout_o is 1 and cclk_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Operating mode code |
| cclk_i | input | 1 | External configuration clock (slave) |
| din_i | input | 1 | Serial configuration data |
| cclk_o | output | 1 | Generated configuration clock (master) |
| cclk_oe_o | output | 1 | Drive enable for cclk_o, high in master operation |
| dout_o | output | 1 | Serial output toward the next device on the chain |
| word_o | output | WORD_W | Assembled configuration word |
| word_valid_o | output | 1 | One-cycle strobe for word_o |
| word_addr_o | output | ADDR_W | Index of the word being delivered |
| done_o | output | 1 | Own load complete |

## Verification
Two events share a cycle at the end of the own load. The strobe for the final word and the rise of done_o fall together, and on the next rising edge the loader must already send the bit to pass-through rather than the packer. The bench runs the stream straight past OWN_BITS with no gap, in slave operation with random phase lengths and in master operation with several rate requests. It checks that done_o is high alongside the last word, that no extra word appears, and that dout_o carries bit OWN_BITS at the first falling edge after it.

A second collision happens in master operation, between the rate request from word 0 and the running divider. The bench measures every rising-to-rising period and checks it against the value expected from the default, the request and the floor, including the one mixed period that straddles the switch.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;

  typedef int unsigned uint_t;

  typedef enum logic [1:0] {
    LM_OFF    = 2'd0,
    LM_MASTER = 2'd1,
    LM_SLAVE  = 2'd2
  } ld_mode_e;

  localparam logic [2:0] CODE_MASTER = 3'b000;
  localparam logic [2:0] CODE_SLAVE  = 3'b111;

  // R1: mode code decode
  function automatic ld_mode_e decode_mode(input logic [2:0] code);
    if (code == CODE_SLAVE)       return LM_SLAVE;
    else if (code == CODE_MASTER) return LM_MASTER;
    else                          return LM_OFF;
  endfunction

  // R5: half-period chosen from a rate request
  function automatic uint_t pick_half(input uint_t cur, input uint_t req,
                                      input uint_t floor_v);
    if (req == 0)            return cur;
    else if (req < floor_v)  return floor_v;
    else                     return req;
  endfunction

endpackage

// File: rtl/cfg_ldr_sync.sv
module cfg_ldr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cclk_in,
  input  logic din_in,
  output logic din_s,
  output logic rise,
  output logic fall
);
  logic [STAGES:0]   ck_q;
  logic [STAGES-1:0] d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q <= '0;
      d_q  <= '0;
    end else begin
      ck_q <= {ck_q[STAGES-1:0], cclk_in};
      d_q  <= {d_q[STAGES-2:0], din_in};
    end
  end

  assign din_s = d_q[STAGES-1];
  assign rise  = ck_q[STAGES-1] & ~ck_q[STAGES];
  assign fall  = ~ck_q[STAGES-1] & ck_q[STAGES];
endmodule

// File: rtl/cfg_ldr_clkgen.sv
module cfg_ldr_clkgen
  import cfg_ldr_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int DEF_HALF = 10,
  parameter int MIN_HALF = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             req_valid,
  input  logic [DIV_W-1:0] req,
  output logic             cclk,
  output logic             rise_evt,
  output logic             fall_evt,
  output logic [DIV_W-1:0] half
);
  localparam logic [DIV_W-1:0] DEF_L = DIV_W'(DEF_HALF);

  logic [DIV_W-1:0] hcnt_q, half_q, pend_q, req_half;
  logic             cclk_q, pend_v_q, taken_q, wrap;

  assign req_half = DIV_W'(pick_half(uint_t'(half_q), uint_t'(req), uint_t'(MIN_HALF)));
  assign wrap     = (hcnt_q == half_q - 1'b1);
  assign rise_evt = run & wrap & ~cclk_q;
  assign fall_evt = run & wrap & cclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q   <= '0;
      half_q   <= DEF_L;
      pend_q   <= DEF_L;
      pend_v_q <= 1'b0;
      taken_q  <= 1'b0;
      cclk_q   <= 1'b0;
    end else begin
      if (!run) begin
        hcnt_q <= '0;
        cclk_q <= 1'b0;
      end else if (wrap) begin
        hcnt_q <= '0;
        cclk_q <= ~cclk_q;
        // R6: new half-period only where the clock falls
        if (cclk_q && pend_v_q) begin
          half_q   <= pend_q;
          pend_v_q <= 1'b0;
        end
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
      // R5: only the first request is honoured
      if (req_valid && !taken_q) begin
        taken_q  <= 1'b1;
        pend_q   <= req_half;
        pend_v_q <= 1'b1;
      end
    end
  end

  assign cclk = cclk_q;
  assign half = half_q;
endmodule

// File: rtl/cfg_ldr_shift.sv
module cfg_ldr_shift #(
  parameter int OWN_BITS = 64,
  parameter int WORD_W   = 8,
  parameter int ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              fall,
  input  logic              din,
  output logic [WORD_W-1:0] word,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic              done,
  output logic              dout
);
  localparam int CNT_W = $clog2(OWN_BITS + 1);
  localparam int BIT_W = $clog2(WORD_W);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sh_q, sh_next, word_q;
  logic [ADDR_W-1:0] addr_q;
  logic              valid_q, pass_q, dout_q, last_bit;

  assign done     = (cnt_q == CNT_W'(OWN_BITS));
  assign last_bit = (cnt_q[BIT_W-1:0] == {BIT_W{1'b1}});
  assign sh_next  = {sh_q[WORD_W-2:0], din};  // R3: first bit ends at MSB

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      word_q  <= '0;
      addr_q  <= '0;
      valid_q <= 1'b0;
      pass_q  <= 1'b1;
      dout_q  <= 1'b1;   // R8 idle level
    end else begin
      valid_q <= 1'b0;
      if (rise) begin
        if (!done) begin
          sh_q  <= sh_next;
          cnt_q <= cnt_q + 1'b1;
          if (last_bit) begin
            word_q  <= sh_next;
            valid_q <= 1'b1;
            addr_q  <= ADDR_W'(cnt_q >> BIT_W);
          end
        end else begin
          pass_q <= din;   // R9 forwarded bit
        end
      end
      if (fall) dout_q <= pass_q;
    end
  end

  assign word  = word_q;
  assign valid = valid_q;
  assign addr  = addr_q;
  assign dout  = dout_q;
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import cfg_ldr_pkg::*;
#(
  parameter int OWN_BITS = 64,
  parameter int WORD_W   = 8,
  parameter int DIV_W    = 8,
  parameter int DEF_HALF = 10,
  parameter int MIN_HALF = 4,
  parameter int ADDR_W   = $clog2(OWN_BITS / WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic              cclk_i,
  input  logic              din_i,
  output logic              cclk_o,
  output logic              cclk_oe_o,
  output logic              dout_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic              done_o
);
  ld_mode_e         ld_mode;
  logic             is_master, is_slave;
  logic             s_rise, s_fall, din_s;
  logic             m_rise, m_fall, m_cclk;
  logic             rise_evt, fall_evt, rate_req_v;
  logic [DIV_W-1:0] cur_half;

  assign ld_mode   = decode_mode(mode_i);   // R1
  assign is_master = (ld_mode == LM_MASTER);
  assign is_slave  = (ld_mode == LM_SLAVE);

  cfg_ldr_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .cclk_in(cclk_i), .din_in(din_i),
    .din_s(din_s), .rise(s_rise), .fall(s_fall)
  );

  assign rate_req_v = is_master & word_valid_o & (word_addr_o == '0);

  cfg_ldr_clkgen #(.DIV_W(DIV_W), .DEF_HALF(DEF_HALF), .MIN_HALF(MIN_HALF)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(is_master), .req_valid(rate_req_v),
    .req(DIV_W'(word_o)), .cclk(m_cclk), .rise_evt(m_rise), .fall_evt(m_fall),
    .half(cur_half)
  );

  always_comb begin
    case (ld_mode)
      LM_MASTER: begin rise_evt = m_rise; fall_evt = m_fall; end
      LM_SLAVE:  begin rise_evt = s_rise; fall_evt = s_fall; end
      default:   begin rise_evt = 1'b0;   fall_evt = 1'b0;   end
    endcase
  end

  cfg_ldr_shift #(.OWN_BITS(OWN_BITS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .rise(rise_evt), .fall(fall_evt), .din(din_s),
    .word(word_o), .valid(word_valid_o), .addr(word_addr_o), .done(done_o),
    .dout(dout_o)
  );

  assign cclk_o    = m_cclk;
  assign cclk_oe_o = is_master;
endmodule

// File: rtl/cfg_ldr_chk.sv
module cfg_ldr_chk
  import cfg_ldr_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       mode_i,
  input logic             cclk_o,
  input logic             done_o,
  input logic             dout_o,
  input logic             word_valid_o,
  input logic             rise_evt,
  input logic [DIV_W-1:0] cur_half
);
  logic off_now;
  assign off_now = (decode_mode(mode_i) == LM_OFF);

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    off_now && $past(off_now) |-> !cclk_o && !word_valid_o); // R1
  AST_WORD_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> $past(rise_evt)); // R3
  AST_HALF_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    cur_half >= DIV_W'(MIN_HALF)); // R5
  AST_DIV_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_half) |-> $fell(cclk_o)); // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o); // R7
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> dout_o); // R8
endmodule

bind serial_cfg_loader cfg_ldr_chk #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cclk_o(cclk_o), .done_o(done_o),
  .dout_o(dout_o), .word_valid_o(word_valid_o), .rise_evt(rise_evt),
  .cur_half(cur_half)
);

// File: tb/test_serial_cfg_loader.sv
module test_serial_cfg_loader;
  localparam int CLK_PERIOD = 10;
  localparam int OWN  = 64;
  localparam int WW   = 8;
  localparam int DEFH = 10;
  localparam int MINH = 4;
  localparam int NW   = OWN / WW;
  localparam int NB   = OWN + 16;
  localparam int AW   = 3;

  logic          clk, rst_n, cclk_i, din_i;
  logic [2:0]    mode_i;
  logic          cclk_o, cclk_oe_o, dout_o, word_valid_o, done_o;
  logic [WW-1:0] word_o;
  logic [AW-1:0] word_addr_o;

  serial_cfg_loader #(.OWN_BITS(OWN), .WORD_W(WW), .DIV_W(8),
                      .DEF_HALF(DEFH), .MIN_HALF(MINH)) i_serial_cfg_loader (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cclk_i(cclk_i), .din_i(din_i),
    .cclk_o(cclk_o), .cclk_oe_o(cclk_oe_o), .dout_o(dout_o), .word_o(word_o),
    .word_valid_o(word_valid_o), .word_addr_o(word_addr_o), .done_o(done_o)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  int   checks = 0, errors = 0, words_seen = 0, rate_cur = 0;
  logic stream [NB];
  logic mon_master = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pack_word(input int idx);
    int w = 0;
    for (int b = 0; b < WW; b++) w = w * 2 + int'(stream[idx*WW + b]);
    return w;
  endfunction

  function automatic int eff_half(input int rate);
    if (rate == 0) return DEFH;
    return (rate < MINH) ? MINH : rate;
  endfunction

  function automatic int exp_period(input int k, input int rate);
    if (rate == 0 || k < WW) return 2 * DEFH;
    if (k == WW) return DEFH + eff_half(rate);
    return 2 * eff_half(rate);
  endfunction

  // word monitor: R3, R7
  always @(negedge clk) begin
    if (rst_n && word_valid_o) begin
      if (words_seen >= NW) chk(1'b0, "R7 word after done", words_seen, NW - 1);
      else begin
        chk(int'(word_o) == pack_word(words_seen), "R3 word value",
            int'(word_o), pack_word(words_seen));
        chk(int'(word_addr_o) == words_seen, "R3 word address",
            int'(word_addr_o), words_seen);
        if (words_seen == NW - 1)
          chk(done_o == 1'b1, "R7 done with final word", int'(done_o), 1);
      end
      words_seen++;
    end
  end

  // generated clock period monitor: R4, R5, R6
  int   since, rise_idx;
  logic prev_ck;
  always @(negedge clk) begin
    if (!rst_n) begin
      since = 0; rise_idx = 0; prev_ck = 1'b0;
    end else if (mon_master) begin
      since++;
      if (cclk_o && !prev_ck) begin
        if (rise_idx >= 1)
          chk(since == exp_period(rise_idx, rate_cur), "R5 R6 cclk period",
              since, exp_period(rise_idx, rate_cur));
        rise_idx++;
        since = 0;
      end
      prev_ck = cclk_o;
    end
  end

  task automatic fill_stream(input int rate);
    for (int i = 0; i < NB; i++) stream[i] = 1'($urandom() & 1);
    for (int b = 0; b < WW; b++) stream[b] = rate[WW-1-b];
  endtask

  task automatic do_reset(input logic [2:0] m);
    rst_n = 1'b0;
    mode_i = m;
    words_seen = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done_o == 1'b0, "R10 reset done", int'(done_o), 0);
    chk(word_valid_o == 1'b0, "R10 reset valid", int'(word_valid_o), 0);
    chk(dout_o == 1'b1, "R10 reset dout", int'(dout_o), 1);
    chk(cclk_o == 1'b0, "R10 reset cclk", int'(cclk_o), 0);
  endtask

  task automatic run_slave();
    fill_stream(int'($urandom() & 8'hff));
    cclk_i = 1'b0; din_i = 1'b0;
    do_reset(3'b111);
    for (int i = 0; i < NB; i++) begin
      int lo = 4 + int'($urandom() % 4);
      int hi = 3 + int'($urandom() % 4);
      din_i = stream[i]; cclk_i = 1'b0;
      repeat (lo) @(negedge clk);
      chk(done_o == (i >= OWN), "R2 R7 slave done timing", int'(done_o), int'(i >= OWN));
      if (i >= 1 && i - 1 >= OWN)
        chk(dout_o == stream[i-1], "R9 slave pass-through", int'(dout_o), int'(stream[i-1]));
      else
        chk(dout_o == 1'b1, "R8 slave idle", int'(dout_o), 1);
      cclk_i = 1'b1;
      repeat (hi) @(negedge clk);
    end
    cclk_i = 1'b0;
    repeat (5) @(negedge clk);
    chk(dout_o == stream[NB-1], "R9 slave last forwarded", int'(dout_o), int'(stream[NB-1]));
    chk(words_seen == NW, "R7 slave word count", words_seen, NW);
    chk(cclk_o == 1'b0 && cclk_oe_o == 1'b0, "R1 slave no clock drive",
        int'({cclk_o, cclk_oe_o}), 0);
  endtask

  task automatic run_master(input int rate);
    logic p;
    fill_stream(rate);
    rate_cur = rate;
    din_i = stream[0]; cclk_i = 1'b0;
    mon_master = 1'b1;
    do_reset(3'b000);
    chk(cclk_oe_o == 1'b1, "R4 master drive enable", int'(cclk_oe_o), 1);
    for (int i = 1; i <= NB; i++) begin
      p = cclk_o;
      forever begin
        @(negedge clk);
        if (p && !cclk_o) break;
        p = cclk_o;
      end
      chk(done_o == (i >= OWN), "R4 R7 master done timing", int'(done_o), int'(i >= OWN));
      if (i - 1 >= OWN)
        chk(dout_o == stream[i-1], "R9 master pass-through", int'(dout_o), int'(stream[i-1]));
      else
        chk(dout_o == 1'b1, "R8 master idle", int'(dout_o), 1);
      if (i < NB) din_i = stream[i];
    end
    chk(words_seen == NW, "R7 master word count", words_seen, NW);
    mon_master = 1'b0;
  endtask

  task automatic run_off();
    fill_stream(5);
    cclk_i = 1'b0;
    do_reset(3'b010);
    for (int i = 0; i < 40; i++) begin
      din_i = stream[i]; cclk_i = 1'b0;
      repeat (4) @(negedge clk);
      cclk_i = 1'b1;
      repeat (4) @(negedge clk);
    end
    chk(words_seen == 0, "R1 off no words", words_seen, 0);
    chk(done_o == 1'b0, "R1 off not done", int'(done_o), 0);
    chk(cclk_o == 1'b0 && cclk_oe_o == 1'b0, "R1 off no clock",
        int'({cclk_o, cclk_oe_o}), 0);
    chk(dout_o == 1'b1, "R1 off dout idle", int'(dout_o), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; mode_i = 3'b111; cclk_i = 1'b0; din_i = 1'b0;
    run_slave();
    run_slave();
    run_master(0);                         // default rate kept
    run_master(6);                         // faster rate
    run_master(2);                         // clamped to floor
    run_master(4 + int'($urandom() % 12)); // random rate
    run_off();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule